// File: doc/BRIEF.md
# Character Bit-Test Branch Unit

This unit is the execute stage of a conditional branch in a machine whose storage holds 6-bit characters. Each storage position also carries a word-mark flag. The unit starts from a decoded instruction, which supplies:

- the instruction length,
- the branch target,
- the operand (B) address,
- a mask character,
- the address of the next sequential instruction.

The unit reads the character at the operand address through a synchronous memory port that holds its request until data is valid. It ANDs the six data bits of that character with the mask. If any bit survives, the branch is taken.

Two registers are rewritten by every operation. The next-instruction register receives the branch target on a taken branch and the sequential address otherwise. The B-address register receives the sequential address on a taken branch and is decremented by one otherwise.

A one-character (chained) form reuses the target, operand address and mask held from the previous operation. Besides normal run mode, a two-step single-cycle mode exists for console stepping. Its first step reads the character and decrements the B address. Its second step evaluates the latched character. A rejected length, an out-of-range address and an unknown step code each finish the operation with a distinct fault pulse. A taken branch emits a one-cycle poll pulse.

Top module: `cbt_branch_unit`

## Requirements
- R1: Only lengths 8 (full form, loads target, operand address and mask from the inputs) and 1 (chained) are accepted. Any other length finishes with `fault_len_o` high for the `done_o` cycle, issues no memory request and leaves `nia_o` and `baddr_o` unchanged.
- R2: An operand address at or above MEM_SIZE (16000 by default) finishes with `fault_addr_o` high and no memory request, leaving `nia_o` and `baddr_o` unchanged. Address MEM_SIZE-1 is accepted.
- R3: The branch is taken when the six data bits (`mem_rdata_i[5:0]`) ANDed with `mask_i` give a nonzero result. A taken branch sets `nia_o` to the target and `baddr_o` to the sequential address, and pulses `poll_o` together with `done_o`.
- R4: The word-mark bit (`mem_rdata_i[6]`) never changes the outcome.
- R5: When the branch is not taken in run mode, `nia_o` becomes the sequential address, `baddr_o` becomes the operand address minus one and `poll_o` stays low.
- R6: A length-1 operation uses the target, the B-address register and the mask held from the previous operation, and ignores the address and mask inputs.
- R7: Step code 01 (first step) reads the character, sets `baddr_o` to the operand address minus one, sets `nia_o` to the sequential address, raises `step_pend_o` and leaves `poll_o` low.
- R8: Step code 10 (second step) issues no memory request. It evaluates the character latched by the first step, even if storage has changed since. A hit gives `nia_o` = target and `baddr_o` = sequential address. A miss gives `nia_o` = sequential address with `baddr_o` unchanged. In both cases `step_pend_o` clears.
- R9: Step code 11 finishes with `diag_o` high, clears `step_pend_o`, issues no memory request and leaves `nia_o` and `baddr_o` unchanged. Code 00 is run mode.
- R10: `mem_req_o` and `mem_addr_o` stay steady from the request until `mem_rvalid_i` is seen. The character is tested only in that cycle, so a read with N wait cycles keeps the request high for N+2 cycles.
- R11: `done_o` is a single-cycle pulse for each accepted start. At most one of the three fault outputs is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation (sampled while idle) |
| mode_i | input | 2 | 00 run, 01 first step, 10 second step, 11 invalid |
| len_i | input | 4 | Decoded instruction length |
| target_i | input | 14 | Branch target address |
| opnd_i | input | 14 | Operand (B) address |
| mask_i | input | 6 | Mask character |
| seq_i | input | 14 | Next sequential instruction address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 7 | Read character, bit 6 is the word mark |
| mem_req_o | output | 1 | Read request, held until valid |
| mem_addr_o | output | 14 | Read address |
| nia_o | output | 14 | Next-instruction address register |
| baddr_o | output | 14 | B-address register |
| done_o | output | 1 | Operation finished (one cycle) |
| poll_o | output | 1 | Branch taken, poll request (one cycle) |
| fault_len_o | output | 1 | Illegal length (with done) |
| fault_addr_o | output | 1 | Invalid operand address (with done) |
| diag_o | output | 1 | Unknown step code (with done) |
| step_pend_o | output | 1 | First step done, second step outstanding |

## Verification
The hardest state to reach from the ports is a second step that runs against a character that no longer matches storage. The bench runs a first step, overwrites the storage location from its memory model, and then issues the second step. The outcome can only follow the latched character.

The unknown-step fault is reached in a similar way. A first step is issued to raise the pending flag, and code 11 is then driven, so the clearing of that flag can be seen. A memory model with a programmable wait count stretches the read to expose the request-hold rule.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

   typedef enum logic [1:0] {
      MODE_RUN    = 2'b00,
      MODE_STEP_A = 2'b01,
      MODE_STEP_B = 2'b10,
      MODE_RSVD   = 2'b11
   } cbt_mode_e;

   typedef enum logic {
      SQ_IDLE = 1'b0,
      SQ_READ = 1'b1
   } cbt_sq_e;

   typedef struct packed {
      logic load_ops;
      logic run_eval;
      logic step_read;
      logic fin_eval;
      logic fail_len;
      logic fail_addr;
      logic fail_mode;
   } cbt_ctl_t;

endpackage

// File: rtl/cbt_addr_check.sv
module cbt_addr_check #(
   parameter int ADDR_W   = 14,
   parameter int MEM_SIZE = 16000
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              ok_o
);
   localparam int CMP_W = ADDR_W + 1;
   localparam logic [CMP_W-1:0] LIMIT = CMP_W'(MEM_SIZE);

   if (MEM_SIZE < 1 || MEM_SIZE > (1 << ADDR_W)) begin : g_bad_size
      $error("cbt_addr_check: MEM_SIZE out of range for ADDR_W");
   end

   assign ok_o = {1'b0, addr_i} < LIMIT;
endmodule

// File: rtl/cbt_bit_test.sv
module cbt_bit_test #(
   parameter int CHAR_W = 6,
   parameter int STYLE  = 0
) (
   input  logic [CHAR_W-1:0] data_i,
   input  logic [CHAR_W-1:0] mask_i,
   output logic              hit_o
);
   if (STYLE != 0 && STYLE != 1) begin : g_bad_style
      $error("cbt_bit_test: STYLE must be 0 or 1");
   end

   if (STYLE == 0) begin : g_reduce
      assign hit_o = |(data_i & mask_i);
   end else begin : g_chain
      logic [CHAR_W:0] acc;
      assign acc[0] = 1'b0;
      for (genvar i = 0; i < CHAR_W; i++) begin : g_bit
         assign acc[i+1] = acc[i] | (data_i[i] & mask_i[i]);
      end
      assign hit_o = acc[CHAR_W];
   end
endmodule

// File: rtl/cbt_seq.sv
module cbt_seq
   import cbt_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      start_i,
   input  cbt_mode_e mode_i,
   input  logic      len_ok_i,
   input  logic      addr_ok_i,
   input  logic      rvalid_i,
   output cbt_ctl_t  ctl_o,
   output logic      mem_req_o
);
   cbt_sq_e   state_q, state_d;
   cbt_mode_e mode_q;

   always_comb begin
      ctl_o   = '0;
      state_d = state_q;
      unique case (state_q)
         SQ_IDLE: begin
            if (start_i) begin
               if (!len_ok_i)                ctl_o.fail_len  = 1'b1;
               else if (!addr_ok_i)          ctl_o.fail_addr = 1'b1;
               else if (mode_i == MODE_RSVD) ctl_o.fail_mode = 1'b1;
               else if (mode_i == MODE_STEP_B) ctl_o.fin_eval = 1'b1;
               else begin
                  ctl_o.load_ops = 1'b1;
                  state_d        = SQ_READ;
               end
            end
         end
         SQ_READ: begin
            if (rvalid_i) begin
               if (mode_q == MODE_RUN) ctl_o.run_eval  = 1'b1;
               else                    ctl_o.step_read = 1'b1;
               state_d = SQ_IDLE;
            end
         end
         default: state_d = SQ_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         mode_q  <= MODE_RUN;
      end else begin
         state_q <= state_d;
         if (state_q == SQ_IDLE && start_i) mode_q <= mode_i;
      end
   end

   assign mem_req_o = (state_q == SQ_READ);

   // R10
   mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !rvalid_i |=> mem_req_o);

   // R10
   read_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && rvalid_i |=> !mem_req_o);
endmodule

// File: rtl/cbt_branch_unit.sv
module cbt_branch_unit
   import cbt_pkg::*;
#(
   parameter int ADDR_W    = 14,
   parameter int MEM_SIZE  = 16000,
   parameter int CHAR_W    = 6,
   parameter int LEN_W     = 4,
   parameter int LEN_FULL  = 8,
   parameter int LEN_CHAIN = 1,
   parameter int TEST_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [1:0]        mode_i,
   input  logic [LEN_W-1:0]  len_i,
   input  logic [ADDR_W-1:0] target_i,
   input  logic [ADDR_W-1:0] opnd_i,
   input  logic [CHAR_W-1:0] mask_i,
   input  logic [ADDR_W-1:0] seq_i,
   input  logic              mem_rvalid_i,
   input  logic [CHAR_W:0]   mem_rdata_i,
   output logic              mem_req_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [ADDR_W-1:0] nia_o,
   output logic [ADDR_W-1:0] baddr_o,
   output logic              done_o,
   output logic              poll_o,
   output logic              fault_len_o,
   output logic              fault_addr_o,
   output logic              diag_o,
   output logic              step_pend_o
);
   localparam logic [LEN_W-1:0]  FULL_C  = LEN_W'(LEN_FULL);
   localparam logic [LEN_W-1:0]  CHAIN_C = LEN_W'(LEN_CHAIN);
   localparam logic [ADDR_W-1:0] ONE_A   = ADDR_W'(1);

   if (LEN_FULL == LEN_CHAIN) begin : g_len_clash
      $error("cbt_branch_unit: the two accepted lengths must differ");
   end
   if (LEN_FULL >= (1 << LEN_W) || LEN_CHAIN >= (1 << LEN_W)) begin : g_len_width
      $error("cbt_branch_unit: LEN_W too narrow for the accepted lengths");
   end
   if (CHAR_W < 1) begin : g_char_w
      $error("cbt_branch_unit: CHAR_W must be positive");
   end

   cbt_mode_e mode;
   logic      is_full, len_ok, use_in, addr_ok, hit;
   logic      wm_unused;
   logic [ADDR_W-1:0] eff_b;
   logic [CHAR_W-1:0] test_data;
   cbt_ctl_t  ctl;

   logic [ADDR_W-1:0] tgt_q, b_q, seq_q, nia_q;
   logic [CHAR_W-1:0] mask_q, char_q;
   logic pend_q, done_q, poll_q, flen_q, faddr_q, diag_q;

   assign mode      = cbt_mode_e'(mode_i);
   assign is_full   = (len_i == FULL_C);
   assign len_ok    = is_full || (len_i == CHAIN_C);
   assign use_in    = is_full && (mode != MODE_STEP_B);
   assign eff_b     = use_in ? opnd_i : b_q;
   assign wm_unused = mem_rdata_i[CHAR_W];
   assign test_data = ctl.fin_eval ? char_q : mem_rdata_i[CHAR_W-1:0];

   cbt_addr_check #(.ADDR_W(ADDR_W), .MEM_SIZE(MEM_SIZE)) addr_chk_i (
      .addr_i (eff_b),
      .ok_o   (addr_ok)
   );

   cbt_bit_test #(.CHAR_W(CHAR_W), .STYLE(TEST_STYLE)) bit_test_i (
      .data_i (test_data),
      .mask_i (mask_q),
      .hit_o  (hit)
   );

   cbt_seq seq_i0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .mode_i    (mode),
      .len_ok_i  (len_ok),
      .addr_ok_i (addr_ok),
      .rvalid_i  (mem_rvalid_i),
      .ctl_o     (ctl),
      .mem_req_o (mem_req_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt_q   <= '0;
         b_q     <= '0;
         seq_q   <= '0;
         nia_q   <= '0;
         mask_q  <= '0;
         char_q  <= '0;
         pend_q  <= 1'b0;
         done_q  <= 1'b0;
         poll_q  <= 1'b0;
         flen_q  <= 1'b0;
         faddr_q <= 1'b0;
         diag_q  <= 1'b0;
      end else begin
         done_q  <= ctl.run_eval | ctl.step_read | ctl.fin_eval |
                    ctl.fail_len | ctl.fail_addr | ctl.fail_mode;
         poll_q  <= (ctl.run_eval | ctl.fin_eval) & hit;
         flen_q  <= ctl.fail_len;
         faddr_q <= ctl.fail_addr;
         diag_q  <= ctl.fail_mode;

         if (ctl.load_ops) begin
            seq_q <= seq_i;
            if (use_in) begin
               tgt_q  <= target_i;
               b_q    <= opnd_i;
               mask_q <= mask_i;
            end
         end

         if (ctl.run_eval) begin
            pend_q <= 1'b0;
            if (hit) begin
               nia_q <= tgt_q;
               b_q   <= seq_q;
            end else begin
               nia_q <= seq_q;
               b_q   <= b_q - ONE_A;
            end
         end

         if (ctl.step_read) begin
            char_q <= mem_rdata_i[CHAR_W-1:0];
            b_q    <= b_q - ONE_A;
            nia_q  <= seq_q;
            pend_q <= 1'b1;
         end

         if (ctl.fin_eval) begin
            pend_q <= 1'b0;
            if (hit) begin
               nia_q <= tgt_q;
               b_q   <= seq_i;
            end else begin
               nia_q <= seq_i;
            end
         end

         if (ctl.fail_mode) pend_q <= 1'b0;
      end
   end

   assign mem_addr_o   = b_q;
   assign nia_o        = nia_q;
   assign baddr_o      = b_q;
   assign done_o       = done_q;
   assign poll_o       = poll_q;
   assign fault_len_o  = flen_q;
   assign fault_addr_o = faddr_q;
   assign diag_o       = diag_q;
   assign step_pend_o  = pend_q;

   // R3
   poll_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      poll_o |-> done_o);

   // R11
   fault_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fault_len_o, fault_addr_o, diag_o}));

   // R2
   bad_addr_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_addr_o |-> done_o && !mem_req_o && !$past(mem_req_o));

   // R9
   diag_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      diag_o |-> !step_pend_o && !poll_o);

   // R7
   step_a_no_poll_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(step_pend_o) |-> done_o && !poll_o);

   // R10
   addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o && !mem_rvalid_i |=> $stable(mem_addr_o));
endmodule

// File: tb/cbt_branch_unit_tb_top.sv
module cbt_branch_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  mode_i = 2'b00;
   logic [3:0]  len_i = 4'd0;
   logic [13:0] target_i = '0, opnd_i = '0, seq_i = '0;
   logic [5:0]  mask_i = '0;
   logic        mem_rvalid_i;
   logic [6:0]  mem_rdata_i;
   logic        mem_req_o, done_o, poll_o, fault_len_o, fault_addr_o, diag_o, step_pend_o;
   logic [13:0] mem_addr_o, nia_o, baddr_o;

   int tests = 0;
   int fails = 0;
   int lat = 0;
   int wcnt = 0;
   logic [6:0] mem [0:255];

   // result capture
   logic [13:0] r_nia, r_b;
   logic r_poll, r_flen, r_faddr, r_diag, r_pend, r_done_seen;
   int   r_reqs;

   always #10 clk = ~clk;

   cbt_branch_unit dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .len_i(len_i),
      .target_i(target_i), .opnd_i(opnd_i), .mask_i(mask_i), .seq_i(seq_i),
      .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i),
      .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .nia_o(nia_o), .baddr_o(baddr_o),
      .done_o(done_o), .poll_o(poll_o), .fault_len_o(fault_len_o),
      .fault_addr_o(fault_addr_o), .diag_o(diag_o), .step_pend_o(step_pend_o)
   );

   // memory model: wait 'lat' cycles, then one valid cycle
   always @(posedge clk) begin
      if (!rst_n || !mem_req_o || mem_rvalid_i) begin
         mem_rvalid_i <= 1'b0;
         wcnt         <= 0;
      end else if (wcnt == lat) begin
         mem_rvalid_i <= 1'b1;
         mem_rdata_i  <= mem[mem_addr_o[7:0]];
      end else begin
         wcnt <= wcnt + 1;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_op(input logic [1:0] md, input logic [3:0] ln, input logic [13:0] tg,
                        input logic [13:0] op, input logic [5:0] mk, input logic [13:0] sq);
      @(negedge clk);
      mode_i = md; len_i = ln; target_i = tg; opnd_i = op; mask_i = mk; seq_i = sq;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      r_reqs = 0;
      r_done_seen = 1'b0;
      for (int k = 0; k < 40; k++) begin
         if (mem_req_o) r_reqs++;
         if (done_o) begin
            r_done_seen = 1'b1;
            r_nia = nia_o; r_b = baddr_o; r_poll = poll_o;
            r_flen = fault_len_o; r_faddr = fault_addr_o; r_diag = diag_o;
            r_pend = step_pend_o;
            break;
         end
         @(negedge clk);
      end
      check("R11", "done seen", int'(r_done_seen), 1);
      @(negedge clk);
      check("R11", "done single cycle", int'(done_o), 0);
   endtask

   task automatic t_reset;
      check("R11", "reset done", int'(done_o), 0);
      check("R10", "reset req", int'(mem_req_o), 0);
      check("R7", "reset pend", int'(step_pend_o), 0);
      check("R3", "reset nia", int'(nia_o), 0);
      check("R5", "reset baddr", int'(baddr_o), 0);
   endtask

   task automatic t_branch_run;
      mem[20] = 7'b0_000101;
      do_op(2'b00, 4'd8, 14'd500, 14'd20, 6'b000100, 14'd108);
      check("R3", "hit nia", int'(r_nia), 500);
      check("R3", "hit baddr", int'(r_b), 108);
      check("R3", "hit poll", int'(r_poll), 1);
      check("R10", "req cycles lat0", r_reqs, 2);
      do_op(2'b00, 4'd8, 14'd500, 14'd20, 6'b001010, 14'd108);
      check("R5", "miss nia", int'(r_nia), 108);
      check("R5", "miss baddr", int'(r_b), 19);
      check("R5", "miss poll", int'(r_poll), 0);
   endtask

   task automatic t_wordmark;
      mem[30] = 7'b1_000000;
      do_op(2'b00, 4'd8, 14'd777, 14'd30, 6'b111111, 14'd200);
      check("R4", "wm alone nia", int'(r_nia), 200);
      check("R4", "wm alone poll", int'(r_poll), 0);
      mem[31] = 7'b1_100000;
      do_op(2'b00, 4'd8, 14'd777, 14'd31, 6'b100000, 14'd210);
      check("R4", "wm with hit nia", int'(r_nia), 777);
      check("R4", "wm with hit baddr", int'(r_b), 210);
   endtask

   task automatic t_chain;
      mem[50] = 7'b0_000010;
      do_op(2'b00, 4'd8, 14'd900, 14'd50, 6'b010001, 14'd300);
      check("R5", "pre-chain nia", int'(r_nia), 300);
      check("R5", "pre-chain baddr", int'(r_b), 49);
      mem[49] = 7'b0_010000;
      mem[2]  = 7'b0_000000;
      do_op(2'b00, 4'd1, 14'd1, 14'd2, 6'b000000, 14'd301);
      check("R6", "chain nia", int'(r_nia), 900);
      check("R6", "chain baddr", int'(r_b), 301);
      check("R6", "chain poll", int'(r_poll), 1);
   endtask

   task automatic t_illegal_len;
      do_op(2'b00, 4'd5, 14'd5, 14'd20, 6'b111111, 14'd9);
      check("R1", "len fault", int'(r_flen), 1);
      check("R1", "len no read", r_reqs, 0);
      check("R1", "len nia kept", int'(r_nia), 900);
      check("R1", "len baddr kept", int'(r_b), 301);
      check("R11", "len other faults", int'(r_faddr) + int'(r_diag), 0);
   endtask

   task automatic t_bad_addr;
      do_op(2'b00, 4'd8, 14'd5, 14'd16000, 6'b111111, 14'd9);
      check("R2", "addr fault", int'(r_faddr), 1);
      check("R2", "addr no read", r_reqs, 0);
      check("R2", "addr nia kept", int'(r_nia), 900);
      check("R2", "addr baddr kept", int'(r_b), 301);
      mem[127] = 7'b0_000000;
      do_op(2'b00, 4'd8, 14'd5, 14'd15999, 6'b111111, 14'd33);
      check("R2", "top addr accepted", int'(r_faddr), 0);
      check("R2", "top addr baddr", int'(r_b), 15998);
   endtask

   task automatic t_latency;
      lat = 3;
      mem[60] = 7'b0_001000;
      do_op(2'b00, 4'd8, 14'd1234, 14'd60, 6'b001000, 14'd400);
      check("R10", "req cycles lat3", r_reqs, 5);
      check("R10", "late data nia", int'(r_nia), 1234);
      check("R10", "late data baddr", int'(r_b), 400);
      lat = 0;
   endtask

   task automatic t_step;
      mem[40] = 7'b0_000011;
      do_op(2'b01, 4'd8, 14'd2000, 14'd40, 6'b000010, 14'd500);
      check("R7", "step A pend", int'(r_pend), 1);
      check("R7", "step A baddr", int'(r_b), 39);
      check("R7", "step A nia", int'(r_nia), 500);
      check("R7", "step A poll", int'(r_poll), 0);
      check("R7", "step A read", r_reqs, 2);
      mem[40] = 7'b0_000000;
      do_op(2'b10, 4'd1, 14'd0, 14'd0, 6'b000000, 14'd500);
      check("R8", "step B latched hit nia", int'(r_nia), 2000);
      check("R8", "step B hit baddr", int'(r_b), 500);
      check("R8", "step B poll", int'(r_poll), 1);
      check("R8", "step B pend clear", int'(r_pend), 0);
      check("R8", "step B no read", r_reqs, 0);
      mem[41] = 7'b0_000011;
      do_op(2'b01, 4'd8, 14'd2100, 14'd41, 6'b110000, 14'd600);
      do_op(2'b10, 4'd1, 14'd0, 14'd0, 6'b000000, 14'd600);
      check("R8", "step B miss nia", int'(r_nia), 600);
      check("R8", "step B miss baddr", int'(r_b), 40);
      check("R8", "step B miss poll", int'(r_poll), 0);
   endtask

   task automatic t_bad_step;
      mem[70] = 7'b0_000001;
      do_op(2'b01, 4'd8, 14'd3000, 14'd70, 6'b000001, 14'd700);
      check("R7", "pend before bad code", int'(r_pend), 1);
      do_op(2'b11, 4'd1, 14'd0, 14'd0, 6'b000000, 14'd1);
      check("R9", "diag raised", int'(r_diag), 1);
      check("R9", "pend cleared", int'(r_pend), 0);
      check("R9", "no read", r_reqs, 0);
      check("R9", "nia kept", int'(r_nia), 700);
      check("R9", "baddr kept", int'(r_b), 69);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 7'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_branch_run();
      t_wordmark();
      t_chain();
      t_illegal_len();
      t_bad_addr();
      t_latency();
      t_step();
      t_bad_step();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule